// File: doc/BRIEF.md
# Pairwise Signed Adder Tree with Aligned Valid

This block reduces a parameterised number of signed partial products to a single signed sum of `SUM_W` bits (32 by default). Operands enter as one packed vector. A per-operand negate mask turns any operand into a subtraction. The operands are combined two at a time, neighbour with neighbour in index order, level after level until one value is left. When a level holds an odd count, its last operand is paired with a constant zero.

A parameter decides whether each tree level is a register stage or plain combinational logic. A second parameter adds one cycle, for when a table-lookup multiplier sits in front of the tree. The input valid flag runs through a chain of flip-flops. These flip-flops clear asynchronously when the active-low reset is asserted. The chain length is the handshake latency, so `out_ready` rises in the same cycle as the matching result on `sum_out`. There is no back-pressure: every accepted beat leaves exactly once, after a fixed delay.

Top module: `pair_adder_tree`

## Requirements
- R1: `sum_out` equals the sum, modulo 2^SUM_W in two's complement, of every operand, each with its negate applied. It shows this value for the input presented LAT cycles earlier, whatever the valid flag was.
- R2: Operand i occupies `ops[i*OP_W +: OP_W]` and is controlled by `neg_mask[i]`. A 1 in the mask subtracts the operand, and a 0 adds it.
- R3: Each operand is a two's-complement value of OP_W bits and is sign-extended to SUM_W bits before summation. For example, 16'h8000 counts as -32768.
- R4: LAT = max(1, ceil(log2 N_OPS)) + 1 + LUT_STAGE. `out_ready` is high exactly LAT clock cycles after `in_valid` was high at a rising edge, and is low otherwise.
- R5: With PIPELINE=0 the levels are combinational. Results and latency are the same as in R1 and R4, including wrap-around at SUM_W bits.
- R6: LUT_STAGE=1 lengthens both the result path and the valid path by one cycle.
- R7: Beats on consecutive cycles are all delivered, in order. The count of `out_ready` cycles equals the count of accepted `in_valid` cycles.
- R8: While `rst_n` is low, `out_ready` is 0 and `sum_out` is 0.
- R9: Odd operand counts, down to N_OPS=1, are zero-padded at each level. With N_OPS=1 the result is the single operand, possibly negated, after a latency of 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Marks the current operand vector as a beat |
| ops | input | N_OPS*OP_W | Packed signed operands, operand 0 in the low bits |
| neg_mask | input | N_OPS | Per-operand subtract select |
| sum_out | output | SUM_W | Signed tree result |
| out_ready | output | 1 | High when `sum_out` carries a beat |

## Verification
A wrong adder or a misplaced pad zero corrupts `sum_out` the first time that pairing carries non-zero data. Such an error is visible exactly LAT cycles after the input that exposes it. A slip in the valid chain or in the tail registers shifts `out_ready` against the data by whole cycles. It therefore appears as a mismatch on the first beat after reset. Sign-extension or negate errors show up only for negative or masked operands, so mask sweeps and extreme values are driven in each of three configurations: pipelined odd N, combinational with the lookup cycle, and a single operand.

// File: rtl/pair_adder_tree.sv
module pair_adder_tree #(
  parameter int N_OPS     = 5,
  parameter int OP_W      = 16,
  parameter int SUM_W     = 32,
  parameter bit PIPELINE  = 1'b1,
  parameter bit LUT_STAGE = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [N_OPS*OP_W-1:0]   ops,
  input  logic [N_OPS-1:0]        neg_mask,
  output logic [SUM_W-1:0]        sum_out,
  output logic                    out_ready
);
  localparam int LEVELS = (N_OPS <= 1) ? 1 : $clog2(N_OPS);
  localparam int LAT    = LEVELS + 1 + int'(LUT_STAGE);
  localparam int TAIL   = PIPELINE ? 1 + int'(LUT_STAGE) : LAT;
  localparam int AGE_W  = $clog2(LAT + 1);

  function automatic int width_at(int lvl);
    int c = N_OPS;
    for (int k = 0; k < lvl; k++) c = (c + 1) / 2;
    return c;
  endfunction

  genvar l;
  for (l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int CNT = width_at(l);
    logic [CNT*SUM_W-1:0] vec;
    if (l == 0) begin : g_in
      always_comb begin
        for (int i = 0; i < N_OPS; i++)
          vec[i*SUM_W +: SUM_W] = neg_mask[i]
            ? -SUM_W'(signed'(ops[i*OP_W +: OP_W]))
            :  SUM_W'(signed'(ops[i*OP_W +: OP_W]));
      end
    end else begin : g_add
      localparam int PC = width_at(l - 1);
      logic [CNT*SUM_W-1:0] nxt;
      always_comb begin
        for (int j = 0; j < CNT; j++) begin
          if (2*j + 1 < PC)
            nxt[j*SUM_W +: SUM_W] = g_lvl[l-1].vec[2*j*SUM_W +: SUM_W]
                                  + g_lvl[l-1].vec[(2*j+1)*SUM_W +: SUM_W];
          else
            nxt[j*SUM_W +: SUM_W] = g_lvl[l-1].vec[2*j*SUM_W +: SUM_W] + SUM_W'(0);
        end
      end
      if (PIPELINE) begin : g_reg
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) vec <= '0;
          else        vec <= nxt;
      end else begin : g_comb
        assign vec = nxt;
      end
    end
  end

  logic [SUM_W-1:0] d_q [TAIL];
  logic [LAT-1:0]   v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < TAIL; k++) d_q[k] <= '0;
      v_q <= '0;
    end else begin
      d_q[0] <= g_lvl[LEVELS].vec;
      for (int k = 1; k < TAIL; k++) d_q[k] <= d_q[k-1];
      v_q <= {v_q[LAT-2:0], in_valid};
    end
  end

  assign sum_out   = d_q[TAIL-1];
  assign out_ready = v_q[LAT-1];

  logic [SUM_W-1:0] ref_sum;
  logic [AGE_W-1:0] age;

  always_comb begin
    ref_sum = '0;
    for (int i = 0; i < N_OPS; i++)
      if (neg_mask[i]) ref_sum = ref_sum - SUM_W'(signed'(ops[i*OP_W +: OP_W]));
      else             ref_sum = ref_sum + SUM_W'(signed'(ops[i*OP_W +: OP_W]));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  age <= '0;
    else if (age != AGE_W'(LAT)) age <= age + 1'b1;

  p_sum_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (age == AGE_W'(LAT)) |-> (sum_out == $past(ref_sum, LAT)));
  p_ready_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (age == AGE_W'(LAT)) |-> (out_ready == $past(in_valid, LAT)));
  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (age != AGE_W'(LAT)) |-> !out_ready);
  p_ready_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(out_ready));
  p_sum_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(sum_out));
endmodule

// File: tb/pair_adder_tree_tb_top.sv
module pair_adder_tree_tb_top;
  localparam int LAT_A = 4;
  localparam int LAT_B = 4;
  localparam int LAT_C = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic in_valid = 1'b0;
  logic [79:0] ops_a = '0;
  logic [4:0]  mask_a = '0;
  logic [95:0] ops_b = '0;
  logic [2:0]  mask_b = '0;
  logic [7:0]  ops_c = '0;
  logic [0:0]  mask_c = '0;
  logic [31:0] sum_a, sum_b, sum_c;
  logic rdy_a, rdy_b, rdy_c;

  always #5 clk = ~clk;

  pair_adder_tree #(.N_OPS(5), .OP_W(16), .SUM_W(32), .PIPELINE(1'b1), .LUT_STAGE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ops(ops_a), .neg_mask(mask_a),
    .sum_out(sum_a), .out_ready(rdy_a));
  pair_adder_tree #(.N_OPS(3), .OP_W(32), .SUM_W(32), .PIPELINE(1'b0), .LUT_STAGE(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ops(ops_b), .neg_mask(mask_b),
    .sum_out(sum_b), .out_ready(rdy_b));
  pair_adder_tree #(.N_OPS(1), .OP_W(8), .SUM_W(32), .PIPELINE(1'b1), .LUT_STAGE(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ops(ops_c), .neg_mask(mask_c),
    .sum_out(sum_c), .out_ready(rdy_c));

  int n_checks = 0;
  int n_fail = 0;
  int beats_in = 0;
  int beats_out = 0;
  bit finished = 1'b0;
  string tag_a = "R8";

  function automatic logic [31:0] exp_sum(input logic [127:0] v, input logic [7:0] m,
                                          input int n, input int w);
    longint acc = 0;
    for (int i = 0; i < n; i++) begin
      logic [63:0] t;
      longint x;
      t = 64'(v >> (i*w));
      x = longint'(t << (64 - w)) >>> (64 - w);
      acc = m[i] ? acc - x : acc + x;
    end
    return 32'(acc);
  endfunction

  logic [7:0]  hv_a, hv_b, hv_c;
  logic [31:0] hs_a [8];
  logic [31:0] hs_b [8];
  logic [31:0] hs_c [8];

  always @(posedge clk) begin
    if (!rst_n) begin
      hv_a <= '0; hv_b <= '0; hv_c <= '0;
      for (int k = 0; k < 8; k++) begin hs_a[k] <= '0; hs_b[k] <= '0; hs_c[k] <= '0; end
    end else begin
      if (in_valid) beats_in <= beats_in + 1;
      hv_a <= {hv_a[6:0], in_valid};
      hv_b <= {hv_b[6:0], in_valid};
      hv_c <= {hv_c[6:0], in_valid};
      hs_a[0] <= exp_sum(128'(ops_a), 8'(mask_a), 5, 16);
      hs_b[0] <= exp_sum(128'(ops_b), 8'(mask_b), 3, 32);
      hs_c[0] <= exp_sum(128'(ops_c), 8'(mask_c), 1, 8);
      for (int k = 1; k < 8; k++) begin
        hs_a[k] <= hs_a[k-1]; hs_b[k] <= hs_b[k-1]; hs_c[k] <= hs_c[k-1];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string ra;
    ra = (tag_a == "R8") ? "R8" : "R4";
    chk(tag_a, sum_a, hs_a[LAT_A-1]);
    chk(ra, 32'(rdy_a), 32'(hv_a[LAT_A-1]));
    chk((tag_a == "R8") ? "R8" : "R5", sum_b, hs_b[LAT_B-1]);
    chk((tag_a == "R8") ? "R8" : "R6", 32'(rdy_b), 32'(hv_b[LAT_B-1]));
    chk((tag_a == "R8") ? "R8" : "R9", sum_c, hs_c[LAT_C-1]);
    chk((tag_a == "R8") ? "R8" : "R9", 32'(rdy_c), 32'(hv_c[LAT_C-1]));
    if (rst_n && rdy_a) beats_out++;
  endtask

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  task automatic rand_inputs();
    ops_a = {$urandom, $urandom, $urandom};
    mask_a = 5'($urandom);
    ops_b = {$urandom, $urandom, $urandom};
    mask_b = 3'($urandom);
    ops_c = 8'($urandom);
    mask_c = 1'($urandom);
  endtask

  initial begin
    #2 rst_n = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R8", {31'd0, rdy_a | rdy_b | rdy_c}, 32'd0);
      chk("R8", sum_a | sum_b | sum_c, 32'd0);
      in_valid = 1'b1;
      rand_inputs();
    end
    in_valid = 1'b0;
    ops_a = '0; ops_b = '0; ops_c = '0; mask_a = '0; mask_b = '0; mask_c = '0;
    step();
    rst_n = 1'b1;

    tag_a = "R2";
    for (int m = 0; m < 32; m++) begin
      step();
      in_valid = 1'b1;
      ops_a = {16'd16, 16'd8, 16'd4, 16'd2, 16'd1};
      mask_a = 5'(m);
      ops_b = {32'd300, 32'd20, 32'd1};
      mask_b = 3'(m);
      ops_c = 8'd77;
      mask_c = 1'(m);
    end

    tag_a = "R3";
    for (int p = 0; p < 32; p++) begin
      step();
      in_valid = p[0];
      for (int i = 0; i < 5; i++) ops_a[i*16 +: 16] = p[i] ? 16'h8000 : 16'h7fff;
      mask_a = 5'(p * 7);
      for (int i = 0; i < 3; i++) ops_b[i*32 +: 32] = p[i+1] ? 32'h8000_0000 : 32'h7fff_ffff;
      mask_b = 3'(p);
      ops_c = p[2] ? 8'h80 : 8'h7f;
      mask_c = 1'(p[3]);
    end

    tag_a = "R1";
    for (int c = 0; c < 1500; c++) begin
      step();
      in_valid = 1'($urandom);
      rand_inputs();
    end

    tag_a = "R7";
    for (int c = 0; c < 60; c++) begin
      step();
      in_valid = 1'b1;
      rand_inputs();
    end
    for (int c = 0; c < 10; c++) begin
      step();
      in_valid = 1'b0;
    end
    chk("R7", 32'(beats_out), 32'(beats_in));

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog R1 actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule